// File: doc/BRIEF.md
# Embedded-Clock 10-Bit Serial Transmitter

The block takes a 10-bit parallel word once per word period and sends it on one serial line as a 12-bit frame. Every frame is framed by a high start bit and a low stop bit, so a receiver can recover the word clock from the data line. The block runs on a bit clock at twelve times the word rate. It samples the word clock as an ordinary input, synchronous to the bit clock, and a selector picks which word-clock edge captures the parallel bus.

Two training inputs replace data frames with a fixed pattern that a receiver can lock onto. The pattern is six ones followed by six zeros. If training is held for several word periods, the parallel bus is frozen. The line drives only after the clock-generation lock flag has been seen, and only while the enable input and the active-low powerdown input are both high. Whether the line is driving is reported on a separate output-enable pin, and all gating decisions are taken at frame boundaries.

Top module: `embedSerTx`

## Requirements
- R1: A data frame is 12 bit times long. Bit 0 is the start bit and is 1. Bits 1 to 10 carry the captured word, least significant bit first. Bit 11 is the stop bit and is 0.
- R2: Frames follow one another with no gap, one frame every 12 bit clocks. The first frame begins on the second bit clock after the lock flag is first sampled high.
- R3: If either training input is high at a frame boundary, the next frame is the training pattern: six 1 bits, then six 0 bits.
- R4: If both training inputs are low at a frame boundary, the next frame is a data frame carrying the most recently captured word.
- R5: While a training input is high, at most 5 selected word-clock edges capture the parallel bus. Later edges leave the held word unchanged until both training inputs have been low for a bit clock.
- R6: With the edge selector at 1, the word is captured on a rising word-clock edge. With the selector at 0, it is captured on a falling edge.
- R7: A frame is driven (output enable at 1) only if enable and powerdown are both 1 at its boundary. Otherwise the output enable is 0 for the whole frame and the serial output is 0.
- R8: Until the lock flag has been sampled high after reset, the output enable stays 0.
- R9: After reset, the output enable and the serial output are both 0.
- R10: The output enable changes only at a frame boundary. It holds one value for all 12 bits of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, twelve times the word rate |
| rstN | input | 1 | Active-low asynchronous reset |
| wordClk | input | 1 | Word clock, synchronous to clk |
| edgeSel | input | 1 | Capture edge: 1 selects rising, 0 selects falling |
| dataIn | input | 10 | Parallel word |
| sync1 | input | 1 | Training request A |
| sync2 | input | 1 | Training request B |
| enable | input | 1 | Line enable |
| pwrdnN | input | 1 | Active-low powerdown |
| pllLock | input | 1 | Clock-generation lock flag |
| serOut | output | 1 | Serial data, 0 while not driving |
| serOe | output | 1 | 1 while the serial line drives |

## Verification
The hardest case to reach is the training hold-off. Its effect cannot be seen while training is active, because the line carries the pattern then. The stimulus keeps a training input high for several whole frames. In the next frame it drops the input late in the word period, after the capture edge and before the frame boundary, so the following frame shows which word was held. The bench runs this once after four training frames and once after five, so both sides of the limit are checked.

// File: rtl/embedSerPkg.sv
package embedSerPkg;
  typedef struct packed {
    logic capture;
    logic load;
    logic sendSync;
    logic driveNext;
  } serStrobes_t;
endpackage

// File: rtl/serCtrl.sv
module serCtrl
  import embedSerPkg::*;
#(
  parameter int FRAME_W   = 12,
  parameter int SYNC_HOLD = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wordClk,
  input  logic        edgeSel,
  input  logic        sync1,
  input  logic        sync2,
  input  logic        enable,
  input  logic        pwrdnN,
  input  logic        pllLock,
  output serStrobes_t strobes
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam int RUN_W = $clog2(SYNC_HOLD + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(SYNC_HOLD);

  logic             wordClkQ;
  logic             locked;
  logic [CNT_W-1:0] bitCnt;
  logic [RUN_W-1:0] syncRun;
  logic             riseSeen, fallSeen, edgeHit, syncAny, atBoundary, holdOff;

  // word clock is sampled in the bit domain; edges found against last sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordClkQ <= 1'b0;
    else       wordClkQ <= wordClk;
  end

  always_comb begin
    riseSeen   = wordClk & ~wordClkQ;
    fallSeen   = ~wordClk & wordClkQ;
    edgeHit    = edgeSel ? riseSeen : fallSeen;
    syncAny    = sync1 | sync2;
    atBoundary = locked && (bitCnt == LAST_BIT);
    holdOff    = (syncRun >= RUN_MAX);
  end

  // sticky lock flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        locked <= 1'b0;
    else if (pllLock) locked <= 1'b1;
  end

  // bit position counter; starts at the last position so the first locked
  // cycle opens a frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            bitCnt <= LAST_BIT;
    else if (locked) begin
      if (bitCnt == LAST_BIT) bitCnt <= '0;
      else                    bitCnt <= bitCnt + 1'b1;
    end
  end

  // count selected edges seen while training is requested
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     syncRun <= '0;
    else if (!syncAny)             syncRun <= '0;
    else if (edgeHit && !holdOff)  syncRun <= syncRun + 1'b1;
  end

  always_comb begin
    strobes.capture   = edgeHit && !holdOff;
    strobes.load      = atBoundary;
    strobes.sendSync  = syncAny;
    strobes.driveNext = enable & pwrdnN;
  end
endmodule

// File: rtl/serDatapath.sv
module serDatapath
  import embedSerPkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  serStrobes_t       strobes,
  output logic              serOut,
  output logic              serOe
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int HALF_W  = FRAME_W / 2;
  localparam logic [FRAME_W-1:0] SYNC_PAT =
    {{(FRAME_W - HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [DATA_W-1:0]  holdWord;
  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] dataFrame;
  logic               oeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdWord <= '0;
    else if (strobes.capture) holdWord <= dataIn;
  end

  // stop bit in the top position, start bit in bit 0, word LSB first between
  assign dataFrame = {1'b0, holdWord, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      oeReg    <= 1'b0;
    end else if (strobes.load) begin
      shiftReg <= strobes.sendSync ? SYNC_PAT : dataFrame;
      oeReg    <= strobes.driveNext;
    end else begin
      shiftReg <= shiftReg >> 1;
    end
  end

  assign serOut = oeReg & shiftReg[0];
  assign serOe  = oeReg;
endmodule

// File: rtl/embedSerTx.sv
module embedSerTx
  import embedSerPkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int SYNC_HOLD = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordClk,
  input  logic              edgeSel,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              sync1,
  input  logic              sync2,
  input  logic              enable,
  input  logic              pwrdnN,
  input  logic              pllLock,
  output logic              serOut,
  output logic              serOe
);
  localparam int FRAME_W = DATA_W + 2;

  serStrobes_t strobes;

  serCtrl #(.FRAME_W(FRAME_W), .SYNC_HOLD(SYNC_HOLD)) uCtrl (
    .clk(clk), .rstN(rstN), .wordClk(wordClk), .edgeSel(edgeSel),
    .sync1(sync1), .sync2(sync2), .enable(enable), .pwrdnN(pwrdnN),
    .pllLock(pllLock), .strobes(strobes)
  );

  serDatapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strobes(strobes),
    .serOut(serOut), .serOe(serOe)
  );
endmodule

// File: rtl/embedSerTx_chk.sv
module embedSerTx_chk
  import embedSerPkg::*;
#(
  parameter int SYNC_HOLD = 5
) (
  input logic        clk,
  input logic        rstN,
  input logic        pllLock,
  input logic        sync1,
  input logic        sync2,
  input logic        serOut,
  input logic        serOe,
  input serStrobes_t strobes
);
  localparam int RUN_W = $clog2(SYNC_HOLD + 1) + 1;

  logic             seenLock;
  logic [RUN_W-1:0] syncCaps;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        seenLock <= 1'b0;
    else if (pllLock) seenLock <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      syncCaps <= '0;
    else if (!(sync1 || sync2))                     syncCaps <= '0;
    else if (strobes.capture && syncCaps < {RUN_W{1'b1}}) syncCaps <= syncCaps + 1'b1;
  end

  // R8
  no_early_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !seenLock |-> !serOe);

  // R10
  oe_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serOe) |-> $past(strobes.load));

  // R1
  start_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.load) && !$past(strobes.sendSync) && serOe) |-> serOut);

  // R3
  sync_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.load) && $past(strobes.sendSync) && serOe) |-> serOut);

  // R7
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.load) |-> (serOe == $past(strobes.driveNext)));

  // R5
  sync_holdoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && (sync1 || sync2)) |-> (syncCaps < RUN_W'(SYNC_HOLD)));

  // R2
  load_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> !strobes.load);
endmodule

bind embedSerTx embedSerTx_chk #(.SYNC_HOLD(SYNC_HOLD)) uChk (
  .clk(clk), .rstN(rstN), .pllLock(pllLock), .sync1(sync1), .sync2(sync2),
  .serOut(serOut), .serOe(serOe), .strobes(strobes)
);

// File: tb/sim_embedSerTx.sv
module sim_embedSerTx;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [11:0] bits;
    logic        oe;
    string       tag;
  } frame_t;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wordClk, edgeSel, sync1, sync2, enable, pwrdnN, pllLock;
  logic [9:0] dataIn;
  logic       serOut, serOe;

  int checks = 0;
  int errors = 0;
  frame_t expQ[$];
  logic [9:0] holdModel = '0;
  int         runModel  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  embedSerTx u0 (
    .clk(clk), .rstN(rstN), .wordClk(wordClk), .edgeSel(edgeSel),
    .dataIn(dataIn), .sync1(sync1), .sync2(sync2), .enable(enable),
    .pwrdnN(pwrdnN), .pllLock(pllLock), .serOut(serOut), .serOe(serOe)
  );

  task automatic check(input logic ok, input string tag, input logic [12:0] act,
                       input logic [12:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one word period of stimulus; pushes the frame expected at the next boundary
  task automatic sendFrame(input logic [9:0] a, input logic [9:0] b, input logic es,
                           input logic s1, input logic s2, input logic late,
                           input logic en, input logic pd, input string tag);
    frame_t     item;
    logic [9:0] capVal;
    capVal = es ? a : b;
    if (s1 | s2) begin
      if (runModel < 5) holdModel = capVal;   // R5 limit
      runModel++;
    end else begin
      runModel  = 0;
      holdModel = capVal;
    end
    if ((s1 | s2) && !late) item.bits = 12'b000000_111111;   // R3 pattern
    else                    item.bits = {1'b0, holdModel, 1'b1}; // R1 layout
    if (late) runModel = 0;
    item.oe = en & pd;
    if (!item.oe) item.bits = '0;
    item.tag = tag;
    expQ.push_back(item);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      case (i)
        0: begin
          dataIn = a; edgeSel = es; sync1 = s1; sync2 = s2;
          enable = en; pwrdnN = pd;
        end
        3:  wordClk = 1'b1;
        6:  dataIn  = b;
        9:  wordClk = 1'b0;
        10: if (late) begin sync1 = 1'b0; sync2 = 1'b0; end
        default: ;
      endcase
    end
  endtask

  task automatic monitor();
    forever begin
      logic [11:0] got;
      logic        oeFirst;
      logic        oeSteady;
      frame_t      exp;
      oeSteady = 1'b1;
      oeFirst  = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        got[i] = serOut;
        if (i == 0) oeFirst = serOe;
        else if (serOe != oeFirst) oeSteady = 1'b0;
      end
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected frame", {oeFirst, got}, 13'h0);
      end else begin
        exp = expQ.pop_front();
        check(oeSteady, "R10 oe changed inside frame", {oeFirst, got}, {exp.oe, exp.bits});
        check((got == exp.bits) && (oeFirst == exp.oe), exp.tag,
              {oeFirst, got}, {exp.oe, exp.bits});
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    frame_t first;
    logic   earlyBad;
    rstN = 1'b0; wordClk = 1'b0; edgeSel = 1'b1; dataIn = '0;
    sync1 = 1'b0; sync2 = 1'b0; enable = 1'b1; pwrdnN = 1'b1; pllLock = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!serOe && !serOut, "R9 reset outputs", {12'h0, serOe}, 13'h0);
    rstN = 1'b1;
    earlyBad = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (serOe || serOut) earlyBad = 1'b1;
    end
    // R8 nothing driven before lock
    check(!earlyBad, "R8 drive before lock", {12'h0, earlyBad}, 13'h0);
    pllLock = 1'b1;
    first.bits = 12'b0000_0000_0001;
    first.oe   = 1'b1;
    first.tag  = "R2 first frame after lock";
    expQ.push_back(first);
    @(posedge clk);
    @(posedge clk);
    fork monitor(); join_none

    sendFrame(10'h2A5, 10'h2A5, 1'b1, 0, 0, 0, 1, 1, "R1 word 2A5");
    sendFrame(10'h15A, 10'h15A, 1'b1, 0, 0, 0, 1, 1, "R1 word 15A");
    sendFrame(10'h0F0, 10'h30C, 1'b0, 0, 0, 0, 1, 1, "R6 falling capture");
    sendFrame(10'h1C7, 10'h238, 1'b1, 0, 0, 0, 1, 1, "R6 rising capture");
    sendFrame(10'h3FF, 10'h3FF, 1'b1, 0, 0, 0, 0, 1, "R7 enable low");
    sendFrame(10'h001, 10'h001, 1'b1, 0, 0, 0, 1, 0, "R7 powerdown");
    sendFrame(10'h2DB, 10'h2DB, 1'b1, 0, 0, 0, 1, 1, "R4 data after gating");
    sendFrame(10'h011, 10'h011, 1'b1, 1, 0, 0, 1, 1, "R3 pattern sync1");
    sendFrame(10'h022, 10'h022, 1'b1, 1, 0, 0, 1, 1, "R3 pattern sync1");
    sendFrame(10'h033, 10'h033, 1'b1, 1, 0, 0, 1, 1, "R3 pattern sync1");
    sendFrame(10'h044, 10'h044, 1'b1, 1, 0, 0, 1, 1, "R3 pattern sync1");
    sendFrame(10'h155, 10'h155, 1'b1, 1, 0, 1, 1, 1, "R5 fifth capture kept");
    sendFrame(10'h101, 10'h101, 1'b0, 0, 1, 0, 1, 1, "R3 pattern sync2");
    sendFrame(10'h102, 10'h102, 1'b0, 0, 1, 0, 1, 1, "R3 pattern sync2");
    sendFrame(10'h103, 10'h103, 1'b0, 0, 1, 0, 1, 1, "R3 pattern sync2");
    sendFrame(10'h104, 10'h104, 1'b0, 0, 1, 0, 1, 1, "R3 pattern sync2");
    sendFrame(10'h105, 10'h105, 1'b0, 0, 1, 0, 1, 1, "R3 pattern sync2");
    sendFrame(10'h0AA, 10'h0AA, 1'b0, 0, 1, 1, 1, 1, "R5 sixth capture ignored");
    sendFrame(10'h0AA, 10'h0AA, 1'b0, 0, 0, 0, 1, 1, "R4 data resumes");
    sendFrame(10'h2C4, 10'h2C4, 1'b1, 1, 1, 0, 0, 1, "R3 both syncs gated R7");
    sendFrame(10'h3C3, 10'h3C3, 1'b1, 0, 0, 0, 1, 1, "R4 data after both syncs");
    sendFrame(10'h000, 10'h000, 1'b1, 0, 0, 0, 1, 1, "R1 all-zero word");

    wait (expQ.size() == 0);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule